// File: doc/BRIEF.md
# Write-Protecting Chip-Select Decoder

This block turns each bus cycle of a small handheld processor into one active-low memory select. The processor has no memory management unit, so protection comes from the decode itself. Two ROM windows answer reads only. RAM answers reads at its main base, but a write there succeeds only while software holds a write-unlock bit. A 96 KB window at address zero is an alias of the start of RAM and can always be written, so running code has a scratch area that needs no unlock. A write that the map refuses drives no select at all, and the block raises a bus-error flag in the next cycle.

RAM is arranged as two equal banks. Bank 0 starts at the RAM base. Its size is a power of two held in a small register, and bank 1 follows it directly with the same size. Bank 0 is divided into 1 MB device-pair selects by decoding three address bits, so up to eight device pairs can hang off that bank. The RAM output-enable goes active for any RAM select and also for a refresh request, which lets pseudo-static devices be refreshed between cycles.

Top module: `memsel_guard`

## Requirements
- R1: For a read cycle, `rom_os_n` is low for addresses 0x10C00000..0x10DFFFFF and `rom_aux_n` is low for 0x10E00000..0x10FFFFFF. Both ROM windows take priority over any RAM bank that overlaps them.
- R2: A write cycle to either ROM window drives every select output high.
- R3: Bank 0 covers RAM_BASE=0x10000000 up to RAM_BASE+S-1, where S = 2^(20+enc) bytes and enc is the size encoding. A permitted access there drives low only `ram_dev_n[k]`, with k = addr[22:20].
- R4: Bank 1 covers RAM_BASE+S up to RAM_BASE+2S-1, and a permitted access there drives `ram_b1_n` low. An address at RAM_BASE+2S or above that misses both ROM windows selects nothing.
- R5: An address below 0x18000 (96 KB) drives `ram_dev_n[0]` low for reads and for writes, whatever the value of `wr_unlock`.
- R6: A write to bank 0 or bank 1 at the main base drives no select when `wr_unlock` is 0. With `wr_unlock` at 1 it selects the device as in R3 or R4.
- R7: `bus_err` is high in the cycle after each cycle whose write was refused (R2 or R6) and low otherwise. It is low after reset.
- R8: After reset the size encoding reads 0 (1 MB). A `cfg_we` cycle with `cfg_wdata` in 0..3 loads it, meaning 1, 2, 4 or 8 MB. Values 4..7 are ignored and leave both `cfg_rdata` and the decode unchanged.
- R9: `ram_oe_n` is low whenever any RAM select is low or `refresh_req` is high, and high otherwise.
- R10: At most one of the select outputs (`rom_os_n`, `rom_aux_n`, `ram_dev_n`, `ram_b1_n`) is low at a time. None is low while `cyc_valid` is 0 or when the address matches no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Byte address of the bus cycle |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_valid | input | 1 | Bus cycle in progress |
| refresh_req | input | 1 | Refresh request for pseudo-static RAM |
| wr_unlock | input | 1 | Software write-unlock for RAM at its main base |
| cfg_we | input | 1 | Load the bank size encoding |
| cfg_wdata | input | 3 | New size encoding (0..3 accepted) |
| cfg_rdata | output | 3 | Current size encoding |
| rom_os_n | output | 1 | OS ROM select, active low |
| rom_aux_n | output | 1 | Second ROM select, active low |
| ram_dev_n | output | 8 | Bank 0 1 MB device-pair selects, active low |
| ram_b1_n | output | 1 | Bank 1 select, active low |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| bus_err | output | 1 | Refused-write flag, one cycle late |

## Verification
The bench sweeps addresses in 256 KB steps from below the RAM base to past the top ROM window. It adds fixed points at every region edge (base-1, base, end, end+1), at the two alias edges and at addresses in the low area. It covers each of the four bank sizes, both read and write, and both unlock states. These sweeps show whether the edge of bank 1 moves with the size, whether ROM wins where an 8 MB bank 1 overlaps it, and whether the alias is writable while the main base is not. The decoded device index is checked inside bank 0. Vectors in which cycle-valid and refresh are switched off separate the output-enable coming from a select from the one coming from refresh. A rejected size value is followed by a decode that must still use the old bank size.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  // Region classes seen by the decoder; order carries no meaning.
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_OS    = 3'd1,
    RG_AUX   = 3'd2,
    RG_ALIAS = 3'd3,
    RG_B0    = 3'd4,
    RG_B1    = 3'd5
  } region_t;

  // Half-open range test with one spare bit so base + bytes cannot wrap.
  function automatic logic in_window(input logic [32:0] a,
                                     input logic [32:0] base,
                                     input logic [32:0] bytes);
    return (a >= base) && (a < (base + bytes));
  endfunction

endpackage

// File: rtl/memsel_cfg.sv
module memsel_cfg #(
  parameter int unsigned CFG_W   = 3,
  parameter int unsigned MAX_ENC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] size_q
);

  logic             load;
  logic [CFG_W-1:0] size_d;

  always_comb begin
    load   = cfg_we && (cfg_wdata <= CFG_W'(MAX_ENC));
    size_d = load ? cfg_wdata : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (load) begin
      size_q <= size_d;
    end
  end

  // R8: an encoding beyond the accepted set leaves the size untouched.
  p_cfg_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata > CFG_W'(MAX_ENC))) |=> $stable(size_q));

  // R8: the stored encoding never leaves the accepted set.
  p_cfg_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_q <= CFG_W'(MAX_ENC));

endmodule

// File: rtl/memsel_region.sv
module memsel_region
  import memsel_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CFG_W       = 3,
  parameter int unsigned DEV_LSB     = 20,
  parameter logic [31:0] RAM_BASE    = 32'h1000_0000,
  parameter logic [31:0] OS_BASE     = 32'h10C0_0000,
  parameter logic [31:0] OS_BYTES    = 32'h0020_0000,
  parameter logic [31:0] AUX_BASE    = 32'h10E0_0000,
  parameter logic [31:0] AUX_BYTES   = 32'h0020_0000,
  parameter logic [31:0] ALIAS_BYTES = 32'h0001_8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  size_enc,
  input  logic              wr_unlock,
  output region_t           region,
  output logic              writable
);

  localparam int unsigned XW = 33;

  logic [XW-1:0] a_x;
  logic [XW-1:0] off_x;
  logic [XW-1:0] bank_bytes;
  logic          above_base;
  logic          os_hit, aux_hit, alias_hit, b0_hit, b1_hit;

  always_comb begin
    a_x        = XW'(addr);
    bank_bytes = XW'(1) << (DEV_LSB + int'(size_enc));
    above_base = a_x >= XW'(RAM_BASE);
    off_x      = a_x - XW'(RAM_BASE);
    os_hit     = in_window(a_x, XW'(OS_BASE), XW'(OS_BYTES));
    aux_hit    = in_window(a_x, XW'(AUX_BASE), XW'(AUX_BYTES));
    alias_hit  = a_x < XW'(ALIAS_BYTES);
    b0_hit     = above_base && (off_x < bank_bytes);
    b1_hit     = above_base && (off_x >= bank_bytes) && (off_x < (bank_bytes << 1));
  end

  // ROM windows win over a large bank 1 that reaches into them.
  always_comb begin
    region   = RG_NONE;
    writable = 1'b0;
    if (os_hit) begin
      region = RG_OS;
    end else if (aux_hit) begin
      region = RG_AUX;
    end else if (alias_hit) begin
      region   = RG_ALIAS;
      writable = 1'b1;
    end else if (b0_hit) begin
      region   = RG_B0;
      writable = wr_unlock;
    end else if (b1_hit) begin
      region   = RG_B1;
      writable = wr_unlock;
    end
  end

endmodule

// File: rtl/memsel_devdec.sv
module memsel_devdec #(
  parameter int unsigned DEV_N = 8,
  parameter int unsigned IDX_W = $clog2(DEV_N)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [DEV_N-1:0] dev_n
);

  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    assign dev_n[g] = ~(en && (idx == IDX_W'(g)));
  end

endmodule

// File: rtl/memsel_guard.sv
module memsel_guard
  import memsel_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CFG_W       = 3,
  parameter int unsigned MAX_ENC     = 3,
  parameter int unsigned DEV_N       = 8,
  parameter int unsigned DEV_LSB     = 20,
  parameter logic [31:0] RAM_BASE    = 32'h1000_0000,
  parameter logic [31:0] OS_BASE     = 32'h10C0_0000,
  parameter logic [31:0] OS_BYTES    = 32'h0020_0000,
  parameter logic [31:0] AUX_BASE    = 32'h10E0_0000,
  parameter logic [31:0] AUX_BYTES   = 32'h0020_0000,
  parameter logic [31:0] ALIAS_BYTES = 32'h0001_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              cyc_valid,
  input  logic              refresh_req,
  input  logic              wr_unlock,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              rom_os_n,
  output logic              rom_aux_n,
  output logic [DEV_N-1:0]  ram_dev_n,
  output logic              ram_b1_n,
  output logic              ram_oe_n,
  output logic              bus_err
);

  localparam int unsigned IDX_W = $clog2(DEV_N);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync[1];

  logic [CFG_W-1:0] size_q;
  region_t          region;
  logic             writable;
  logic             blocked;
  logic             go;
  logic             dev_en;
  logic [IDX_W-1:0] dev_idx;
  logic             bus_err_d;

  memsel_cfg #(
    .CFG_W   (CFG_W),
    .MAX_ENC (MAX_ENC)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .size_q    (size_q)
  );

  memsel_region #(
    .ADDR_W      (ADDR_W),
    .CFG_W       (CFG_W),
    .DEV_LSB     (DEV_LSB),
    .RAM_BASE    (RAM_BASE),
    .OS_BASE     (OS_BASE),
    .OS_BYTES    (OS_BYTES),
    .AUX_BASE    (AUX_BASE),
    .AUX_BYTES   (AUX_BYTES),
    .ALIAS_BYTES (ALIAS_BYTES)
  ) u_region (
    .addr      (addr),
    .size_enc  (size_q),
    .wr_unlock (wr_unlock),
    .region    (region),
    .writable  (writable)
  );

  always_comb begin
    blocked   = cyc_valid && wr && (region != RG_NONE) && !writable;
    go        = cyc_valid && !blocked;
    rom_os_n  = ~(go && (region == RG_OS));
    rom_aux_n = ~(go && (region == RG_AUX));
    ram_b1_n  = ~(go && (region == RG_B1));
    dev_en    = go && ((region == RG_B0) || (region == RG_ALIAS));
    dev_idx   = (region == RG_ALIAS) ? '0 : addr[DEV_LSB +: IDX_W];
    bus_err_d = blocked;
  end

  memsel_devdec #(
    .DEV_N (DEV_N),
    .IDX_W (IDX_W)
  ) u_devdec (
    .en    (dev_en),
    .idx   (dev_idx),
    .dev_n (ram_dev_n)
  );

  always_comb begin
    ram_oe_n = ~((~&ram_dev_n) || !ram_b1_n || refresh_req);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      bus_err <= 1'b0;
    end else begin
      bus_err <= bus_err_d;
    end
  end

  assign cfg_rdata = size_q;

  // ---------------- assertions ----------------
  logic [DEV_N+2:0] all_sel_n;
  logic             rom_addr;

  always_comb begin
    all_sel_n = {rom_os_n, rom_aux_n, ram_dev_n, ram_b1_n};
    rom_addr  = in_window(33'(addr), 33'(OS_BASE), 33'(OS_BYTES)) ||
                in_window(33'(addr), 33'(AUX_BASE), 33'(AUX_BYTES));
  end

  // R10: never two selects at once.
  p_one_sel_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(~all_sel_n));

  // R10: no select without a bus cycle.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cyc_valid |-> (&all_sel_n));

  // R2: a ROM write drives nothing.
  p_rom_wr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cyc_valid && wr && rom_addr) |-> (&all_sel_n));

  // R7: a ROM write is flagged in the next cycle.
  p_rom_wr_err_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cyc_valid && wr && rom_addr) |=> bus_err);

  // R7: the flag only ever follows a write cycle.
  p_err_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_err |-> $past(cyc_valid && wr));

  // R5: the low alias always reaches the first device pair.
  p_alias_open_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cyc_valid && (33'(addr) < 33'(ALIAS_BYTES))) |-> !ram_dev_n[0]);

  // R9: refresh forces the output-enable.
  p_oe_refresh_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    refresh_req |-> !ram_oe_n);

endmodule

// File: tb/memsel_guard_bench.sv
module memsel_guard_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic        wr, cyc_valid, refresh_req, wr_unlock, cfg_we;
  logic [2:0]  cfg_wdata, cfg_rdata;
  logic        rom_os_n, rom_aux_n, ram_b1_n, ram_oe_n, bus_err;
  logic [7:0]  ram_dev_n;

  int checks   = 0;
  int failures = 0;
  int vec_n    = 0;
  int cur_enc  = 0;

  always #(CLK_P/2) clk = ~clk;

  memsel_guard u_memsel_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .cyc_valid(cyc_valid),
    .refresh_req(refresh_req), .wr_unlock(wr_unlock), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rom_os_n(rom_os_n),
    .rom_aux_n(rom_aux_n), .ram_dev_n(ram_dev_n), .ram_b1_n(ram_b1_n),
    .ram_oe_n(ram_oe_n), .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s addr=%08h act=%0h exp=%0h", tag, addr, act, exp);
    end
  endtask

  // Expected selects {os, aux, dev[7:0], b1} active high, plus refusal.
  task automatic model(input logic [31:0] a, input logic w, input logic v,
                       input logic un, output logic [10:0] es,
                       output logic eb, output string tg);
    longint unsigned s, off;
    bit rom_os, rom_aux, low, b0, b1, above;
    s       = 64'd1 << (20 + cur_enc);
    rom_os  = (a >= 32'h10C0_0000) && (a < 32'h10E0_0000);
    rom_aux = (a >= 32'h10E0_0000) && (a < 32'h1100_0000);
    low     = a < 32'h0001_8000;
    above   = a >= 32'h1000_0000;
    off     = longint'(a) - 64'h1000_0000;
    b0      = above && (off < s);
    b1      = above && (off >= s) && (off < 2*s);
    es = '0; eb = 1'b0; tg = "R10";
    if (rom_os || rom_aux) begin
      tg = w ? "R2" : "R1";
      if (v && w) eb = 1'b1;
      else if (v) es[rom_os ? 10 : 9] = 1'b1;
    end else if (low) begin
      tg = "R5";
      if (v) es[1] = 1'b1;
    end else if (b0) begin
      tg = (w && !un) ? "R6" : "R3";
      if (v && w && !un) eb = 1'b1;
      else if (v) es[1 + int'(a[22:20])] = 1'b1;
    end else if (b1) begin
      tg = (w && !un) ? "R6" : "R4";
      if (v && w && !un) eb = 1'b1;
      else if (v) es[0] = 1'b1;
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic w, input logic un);
    logic [10:0] es, got;
    logic        eb, v, rf;
    string       tg;
    v  = (vec_n % 7) != 3;
    rf = (vec_n % 5) == 2;
    vec_n++;
    @(negedge clk);
    addr = a; wr = w; cyc_valid = v; refresh_req = rf; wr_unlock = un;
    model(a, w, v, un, es, eb, tg);
    #1;
    got = {~rom_os_n, ~rom_aux_n, ~ram_dev_n, ~ram_b1_n};
    chk(got == es, tg, 32'(got), 32'(es));
    chk($countones(got) <= 1, "R10", 32'(got), 32'(es));
    chk(ram_oe_n == !((|es[8:0]) || rf), "R9", 32'(ram_oe_n), 32'(!((|es[8:0]) || rf)));
    @(posedge clk);
    #1;
    chk(bus_err == eb, "R7", 32'(bus_err), 32'(eb));
  endtask

  task automatic cfg_write(input logic [2:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d; cyc_valid = 1'b0; refresh_req = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    if (d <= 3'd3) cur_enc = int'(d);
    #1;
    chk(cfg_rdata == 3'(cur_enc), "R8", 32'(cfg_rdata), 32'(cur_enc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst_n = 1'b0; addr = '0; wr = 1'b0; cyc_valid = 1'b0; refresh_req = 1'b0;
    wr_unlock = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: R8 encoding zero, R7 flag low, R10 quiet bus.
    chk(cfg_rdata == 3'd0, "R8", 32'(cfg_rdata), 0);
    chk(bus_err == 1'b0, "R7", 32'(bus_err), 0);
    chk({rom_os_n, rom_aux_n, ram_dev_n, ram_b1_n} == 11'h7FF, "R10",
        32'({rom_os_n, rom_aux_n, ram_dev_n, ram_b1_n}), 32'h7FF);
    // Default 1 MB: bank 1 begins at base + 1 MB (R4).
    apply(32'h1010_0000, 1'b0, 1'b0);

    for (int e = 0; e < 4; e++) begin
      cfg_write(3'(e));
      s = 32'd1 << (20 + e);
      for (int u = 0; u < 2; u++) begin
        for (int w = 0; w < 2; w++) begin
          for (int k = 0; k <= 80; k++)
            apply(32'h0FC0_0000 + 32'(k) * 32'h0004_0000, 1'(w), 1'(u));
          for (int k = 0; k < 16; k++)
            apply(32'(k) * 32'h0000_2000, 1'(w), 1'(u));
          apply(32'h0001_7FFF, 1'(w), 1'(u));
          apply(32'h0001_8000, 1'(w), 1'(u));
          apply(32'h0FFF_FFFF, 1'(w), 1'(u));
          apply(32'h1000_0000, 1'(w), 1'(u));
          apply(32'h1000_0000 + s - 1, 1'(w), 1'(u));
          apply(32'h1000_0000 + s, 1'(w), 1'(u));
          apply(32'h1000_0000 + 2*s - 1, 1'(w), 1'(u));
          apply(32'h1000_0000 + 2*s, 1'(w), 1'(u));
          apply(32'h10BF_FFFF, 1'(w), 1'(u));
          apply(32'h10C0_0000, 1'(w), 1'(u));
          apply(32'h10DF_FFFF, 1'(w), 1'(u));
          apply(32'h10E0_0000, 1'(w), 1'(u));
          apply(32'h10FF_FFFF, 1'(w), 1'(u));
          apply(32'h1100_0000, 1'(w), 1'(u));
          apply(32'hFFFF_FFFF, 1'(w), 1'(u));
        end
      end
    end

    // R8: rejected encodings keep a 4 MB bank; decode proves it.
    cfg_write(3'd2);
    cfg_write(3'd5);
    cfg_write(3'd7);
    apply(32'h1030_0000, 1'b0, 1'b0);
    apply(32'h1040_0000, 1'b0, 1'b0);
    // Back-to-back refused writes keep the flag up (R7).
    apply(32'h10C0_0010, 1'b1, 1'b0);
    apply(32'h1000_0010, 1'b1, 1'b0);
    apply(32'h0000_0010, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule